// File: doc/BRIEF.md
# Stack Transfer Engine

This block moves 16-bit register pairs between a register file and a byte-wide memory through a 16-bit stack pointer that it owns. A decode stage issues one command at a time on a single-cycle `cmd_valid` strobe. The command can push a pair, pop a pair, swap the HL pair with the two bytes on top of the stack, or load the stack pointer from HL. Call and return logic use two further command codes to push and pop the program counter in the same byte order as a register pair.

Each command runs as a short sequence with at most one byte access to memory per clock. Memory is synchronous: read data appears on `mem_rdata` one clock after `mem_re`. `busy` stays high for every cycle of a sequence. `done` then pulses for one cycle, with `rsp_data` holding any word that was read. `rsp_pair` and `rsp_to_pc` tell the register file where that word belongs. The engine does not modify a pushed pair. The pair comes in on `cmd_data` and the engine only copies it.

Top module: `stk_engine`

## Requirements
- R1: Command code 0 pushes `cmd_data`. In the first busy cycle the high byte is written at SP-1. In the second busy cycle the low byte is written at SP-2. SP ends 2 below its starting value, and `done` follows the two busy cycles.
- R2: Command code 1 pops a pair. The byte at SP becomes `rsp_data[7:0]` and the byte at SP+1 becomes `rsp_data[15:8]`. SP ends 2 above its starting value. There are three busy cycles, then `done`.
- R3: Pair selector code 3 is the accumulator pair. The accumulator travels in `cmd_data[15:8]` and `rsp_data[15:8]`, and the flag byte travels in bits [7:0], in the same order as any other pair. On push and pop, `rsp_pair` returns the selector given with the command.
- R4: Command code 2 exchanges with the top of stack. The old bytes at SP and SP+1 are returned as `rsp_data` (low, high). L (`cmd_data[7:0]`) is written at SP and H (`cmd_data[15:8]`) at SP+1. SP does not change, `rsp_pair` reads 2 (HL), and there are four busy cycles.
- R5: Command code 3 copies `cmd_data` into SP. There is one busy cycle and no memory access.
- R6: Command code 4 pushes a program counter in the R1 order. Command code 5 pops it in the R2 order. `rsp_to_pc` is 1 at `done` for code 5 and 0 for register pops.
- R7: Stack pointer arithmetic and stack addresses wrap modulo 65536.
- R8: At most one memory access happens per clock, so `mem_we` and `mem_re` are never both high, and memory is touched only while `busy` is high. `done` lasts exactly one cycle, with `busy` low.
- R9: The engine ignores a command presented while `busy` is high. It also ignores command codes 6 and 7: no busy cycle, no `done`, no memory access, and SP unchanged.
- R10: After reset, SP equals the `SP_RESET` parameter and `busy`, `done`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 exchange, 3 load SP, 4 PC push, 5 PC pop) |
| cmd_pair | input | 2 | Pair selector (0 BC, 1 DE, 2 HL, 3 accumulator and flags) |
| cmd_data | input | 16 | Word to push, HL for exchange and load SP |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Word read by pop or exchange |
| rsp_pair | output | 2 | Destination pair of `rsp_data` |
| rsp_to_pc | output | 1 | `rsp_data` belongs to the program counter |
| sp_value | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable, data on the next clock |
| mem_rdata | input | 8 | Read byte |

## Verification
The bench keeps the default 16-bit pair and address widths and overrides `SP_RESET` to 1. With that value, the very first push out of reset writes at address 0x0000 and then at 0xFFFF, and the following pop reads back across the same boundary. The wrap case is therefore covered without first loading the stack pointer. Every other scenario starts from a stack pointer loaded through command code 3, which places the stack in a region that is clear of the wrap addresses.

// File: rtl/stk_pkg.sv
// Shared encodings for the stack transfer engine.
// Assumes a 3-bit command code and a 2-bit pair selector.
package stk_pkg;

    localparam int PSEL_W = 2;
    localparam logic [PSEL_W-1:0] PSEL_HL = 2'd2;

    typedef enum logic [2:0] {
        OP_PUSH   = 3'd0,
        OP_POP    = 3'd1,
        OP_XTOP   = 3'd2,
        OP_SPLD   = 3'd3,
        OP_PCPUSH = 3'd4,
        OP_PCPOP  = 3'd5
    } stk_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_HI,
        ST_PU_LO,
        ST_PO_LO,
        ST_PO_HI,
        ST_PO_FIN,
        ST_XR_LO,
        ST_XR_HI,
        ST_XW_LO,
        ST_XW_HI,
        ST_SPLD
    } stk_state_e;

    typedef struct packed {
        logic load;
        logic inc;
        logic dec;
    } sp_ctl_t;

endpackage

// File: rtl/stk_sp_reg.sv
// Stack pointer register.
// Load has priority over increment, and increment over decrement.
// Arithmetic wraps at the register width.
module stk_sp_reg #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  stk_pkg::sp_ctl_t    ctl,
    input  logic [ADDR_W-1:0]   load_val,
    output logic [ADDR_W-1:0]   sp
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Update the pointer from the sequencer's one-hot control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else if (ctl.load) begin
            sp <= load_val;
        end else if (ctl.inc) begin
            sp <= sp + STEP;
        end else if (ctl.dec) begin
            sp <= sp - STEP;
        end
    end

endmodule

// File: rtl/stk_byte_gather.sv
// Assembles two bytes read from memory into one word.
// Assumes each capture strobe arrives on the cycle its byte is valid.
module stk_byte_gather #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [BYTE_W-1:0]     rdata,
    output logic [2*BYTE_W-1:0]   word
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Capture each half when the sequencer flags it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= rdata;
            if (cap_hi) hi_q <= rdata;
        end
    end

    assign word = {hi_q, lo_q};

endmodule

// File: rtl/stk_seq.sv
// Command sequencer for the stack transfer engine.
// Takes one command when idle, then steps through one memory byte per
// clock. Assumes memory returns read data one clock after mem_re.
module stk_seq #(
    parameter int ADDR_W = 16,
    parameter int PAIR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [stk_pkg::PSEL_W-1:0]  cmd_pair,
    input  logic [PAIR_W-1:0]           cmd_data,
    input  logic [ADDR_W-1:0]           sp,
    output stk_pkg::sp_ctl_t            sp_ctl,
    output logic [ADDR_W-1:0]           sp_load_val,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [PAIR_W/2-1:0]         mem_wdata,
    output logic                        mem_we,
    output logic                        mem_re,
    output logic                        cap_lo,
    output logic                        cap_hi,
    output logic                        busy,
    output logic                        done,
    output logic [stk_pkg::PSEL_W-1:0]  rsp_pair,
    output logic                        rsp_to_pc
);
    import stk_pkg::*;

    localparam int BYTE_W = PAIR_W / 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    stk_state_e          state, state_d;
    logic [PAIR_W-1:0]   data_q;
    logic [PSEL_W-1:0]   pair_q;
    logic                pc_q;
    logic                done_q;
    logic                fin;
    stk_op_e             op_in;

    assign op_in = stk_op_e'(cmd_op);

    // Next state and end-of-sequence detection.
    always_comb begin
        state_d = state;
        fin     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op_in)
                        OP_PUSH, OP_PCPUSH: state_d = ST_PU_HI;
                        OP_POP, OP_PCPOP:   state_d = ST_PO_LO;
                        OP_XTOP:            state_d = ST_XR_LO;
                        OP_SPLD:            state_d = ST_SPLD;
                        default:            state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PU_HI:  state_d = ST_PU_LO;
            ST_PU_LO:  begin state_d = ST_IDLE; fin = 1'b1; end
            ST_PO_LO:  state_d = ST_PO_HI;
            ST_PO_HI:  state_d = ST_PO_FIN;
            ST_PO_FIN: begin state_d = ST_IDLE; fin = 1'b1; end
            ST_XR_LO:  state_d = ST_XR_HI;
            ST_XR_HI:  state_d = ST_XW_LO;
            ST_XW_LO:  state_d = ST_XW_HI;
            ST_XW_HI:  begin state_d = ST_IDLE; fin = 1'b1; end
            ST_SPLD:   begin state_d = ST_IDLE; fin = 1'b1; end
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, command latches and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
            pair_q <= '0;
            pc_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            state  <= state_d;
            done_q <= fin;
            if (state == ST_IDLE && cmd_valid && state_d != ST_IDLE) begin
                data_q <= cmd_data;
                pc_q   <= (op_in == OP_PCPUSH) || (op_in == OP_PCPOP);
                pair_q <= (op_in == OP_XTOP) ? PSEL_HL : cmd_pair;
            end
        end
    end

    // Memory port, pointer control and capture strobes for each step.
    always_comb begin
        mem_addr  = sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        sp_ctl    = '0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        case (state)
            ST_PU_HI: begin
                mem_addr   = sp - STEP;
                mem_wdata  = data_q[PAIR_W-1:BYTE_W];
                mem_we     = 1'b1;
                sp_ctl.dec = 1'b1;
            end
            ST_PU_LO: begin
                mem_addr   = sp - STEP;
                mem_wdata  = data_q[BYTE_W-1:0];
                mem_we     = 1'b1;
                sp_ctl.dec = 1'b1;
            end
            ST_PO_LO: begin
                mem_re     = 1'b1;
                sp_ctl.inc = 1'b1;
            end
            ST_PO_HI: begin
                mem_re     = 1'b1;
                sp_ctl.inc = 1'b1;
                cap_lo     = 1'b1;
            end
            ST_PO_FIN: cap_hi = 1'b1;
            ST_XR_LO:  mem_re = 1'b1;
            ST_XR_HI: begin
                mem_addr = sp + STEP;
                mem_re   = 1'b1;
                cap_lo   = 1'b1;
            end
            ST_XW_LO: begin
                mem_wdata = data_q[BYTE_W-1:0];
                mem_we    = 1'b1;
                cap_hi    = 1'b1;
            end
            ST_XW_HI: begin
                mem_addr  = sp + STEP;
                mem_wdata = data_q[PAIR_W-1:BYTE_W];
                mem_we    = 1'b1;
            end
            ST_SPLD:  sp_ctl.load = 1'b1;
            default: ;
        endcase
    end

    assign sp_load_val = ADDR_W'(data_q);
    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign rsp_pair    = pair_q;
    assign rsp_to_pc   = pc_q;

endmodule

// File: rtl/stk_engine.sv
// Stack transfer engine top level.
// Connects the sequencer, the stack pointer and the read-word assembler.
// Assumes PAIR_W equals ADDR_W, so that HL can load SP directly.
module stk_engine #(
    parameter int ADDR_W = 16,
    parameter int PAIR_W = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [1:0]         cmd_pair,
    input  logic [PAIR_W-1:0]  cmd_data,
    output logic               busy,
    output logic               done,
    output logic [PAIR_W-1:0]  rsp_data,
    output logic [1:0]         rsp_pair,
    output logic               rsp_to_pc,
    output logic [ADDR_W-1:0]  sp_value,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [PAIR_W/2-1:0] mem_wdata,
    output logic               mem_we,
    output logic               mem_re,
    input  logic [PAIR_W/2-1:0] mem_rdata
);

    localparam int BYTE_W = PAIR_W / 2;

    stk_pkg::sp_ctl_t    sp_ctl;
    logic [ADDR_W-1:0]   sp_load_val;
    logic                cap_lo;
    logic                cap_hi;

    stk_seq #(.ADDR_W(ADDR_W), .PAIR_W(PAIR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_pair   (cmd_pair),
        .cmd_data   (cmd_data),
        .sp         (sp_value),
        .sp_ctl     (sp_ctl),
        .sp_load_val(sp_load_val),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .busy       (busy),
        .done       (done),
        .rsp_pair   (rsp_pair),
        .rsp_to_pc  (rsp_to_pc)
    );

    stk_sp_reg #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (sp_ctl),
        .load_val(sp_load_val),
        .sp      (sp_value)
    );

    stk_byte_gather #(.BYTE_W(BYTE_W)) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_lo(cap_lo),
        .cap_hi(cap_hi),
        .rdata (mem_rdata),
        .word  (rsp_data)
    );

endmodule

// File: rtl/stk_engine_chk.sv
// Protocol and stack pointer checks for stk_engine, attached by bind.
// Assumes the command codes listed in the brief.
module stk_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_data_sp,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] sp_value,
    input logic              mem_we,
    input logic              mem_re
);

    logic take;
    assign take = cmd_valid && !busy;

    // R8: never a read and a write in the same clock
    p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8: memory is touched only inside a sequence
    p_access_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    // R8: done is a single-cycle pulse outside busy
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R1: a push ends two below the starting pointer
    p_push_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == 3'd0 || cmd_op == 3'd4)) |=> ##2
        (done && sp_value == $past(sp_value, 3) - ADDR_W'(2)));

    // R2: a pop ends two above the starting pointer
    p_pop_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == 3'd1 || cmd_op == 3'd5)) |=> ##3
        (done && sp_value == $past(sp_value, 4) + ADDR_W'(2)));

    // R4: the exchange leaves the pointer where it was
    p_xtop_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 3'd2) |=> ##4
        (done && sp_value == $past(sp_value, 5)));

    // R5: load SP takes the command word
    p_spld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 3'd3) |=> ##1
        (done && sp_value == $past(cmd_data_sp, 2)));

    // R9: undefined codes start nothing
    p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op[2:1] == 2'b11) |=> (!busy && $stable(sp_value)));

endmodule

bind stk_engine stk_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data_sp(cmd_data[ADDR_W-1:0]),
    .busy       (busy),
    .done       (done),
    .sp_value   (sp_value),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
);

// File: tb/tb_stk_engine.sv
`timescale 1ns/1ps
// Directed bench for stk_engine: one task per scenario.
module tb_stk_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_pair;
    logic [15:0] cmd_data;
    logic        busy, done, rsp_to_pc, mem_we, mem_re;
    logic [15:0] rsp_data, sp_value, mem_addr;
    logic [1:0]  rsp_pair;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  mem [256];
    logic [15:0] wlog_a [64];
    logic [7:0]  wlog_d [64];
    int          wn = 0;
    int          rn = 0;

    always #10 clk = ~clk;

    stk_engine #(.ADDR_W(16), .PAIR_W(16), .SP_RESET(16'h0001)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pair(cmd_pair), .cmd_data(cmd_data), .busy(busy), .done(done),
        .rsp_data(rsp_data), .rsp_pair(rsp_pair), .rsp_to_pc(rsp_to_pc),
        .sp_value(sp_value), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Synchronous byte memory with a write log.
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wlog_a[wn % 64]    <= mem_addr;
            wlog_d[wn % 64]    <= mem_wdata;
            wn                 <= wn + 1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rn        <= rn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Present one command for one cycle; returns at the first busy negedge.
    task automatic issue(input logic [2:0] op, input logic [1:0] pr, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pair = pr; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Count busy cycles until done, then check done drops after one cycle.
    task automatic wait_done(input string req, output int nbusy);
        int n = 0;
        nbusy = 0;
        while (!done && n < 20) begin
            if (busy) nbusy++;
            @(negedge clk);
            n++;
        end
        chk({req, " done seen"}, done, 1'b1);
        chk({req, " busy low at done"}, busy, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_pair = '0; cmd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 sp", sp_value, 16'h0001);
        chk("R10 busy/done", {busy, done}, 2'b00);
        chk("R10 mem idle", {mem_we, mem_re}, 2'b00);
    endtask

    task automatic t_wrap();
        int b, nb;
        b = wn;
        issue(3'd0, 2'd0, 16'hA1B2);
        wait_done("R7 push", nb);
        chk("R7 high addr", wlog_a[b % 64], 16'h0000);
        chk("R7 low addr", wlog_a[(b + 1) % 64], 16'hFFFF);
        chk("R7 sp after push", sp_value, 16'hFFFF);
        issue(3'd1, 2'd1, 16'h0);
        wait_done("R7 pop", nb);
        chk("R7 pop data", rsp_data, 16'hA1B2);
        chk("R7 sp after pop", sp_value, 16'h0001);
    endtask

    task automatic t_spld();
        int b, r, nb;
        b = wn; r = rn;
        issue(3'd3, 2'd2, 16'h2000);
        wait_done("R5", nb);
        chk("R5 sp", sp_value, 16'h2000);
        chk("R5 busy cycles", nb, 1);
        chk("R5 no access", (wn - b) + (rn - r), 0);
    endtask

    task automatic t_push();
        int b, nb;
        b = wn;
        issue(3'd0, 2'd1, 16'h1234);
        wait_done("R1", nb);
        chk("R1 busy cycles", nb, 2);
        chk("R1 first write", {wlog_a[b % 64], wlog_d[b % 64]}, {16'h1FFF, 8'h12});
        chk("R1 second write", {wlog_a[(b + 1) % 64], wlog_d[(b + 1) % 64]}, {16'h1FFE, 8'h34});
        chk("R1 sp", sp_value, 16'h1FFE);
        @(negedge clk);
        chk("R8 done one cycle", done, 1'b0);
    endtask

    task automatic t_accum();
        int b, nb;
        b = wn;
        issue(3'd0, 2'd3, 16'hC3D5);
        wait_done("R3 push", nb);
        chk("R3 accumulator at SP-1", {wlog_a[b % 64], wlog_d[b % 64]}, {16'h1FFD, 8'hC3});
        chk("R3 flags at SP-2", {wlog_a[(b + 1) % 64], wlog_d[(b + 1) % 64]}, {16'h1FFC, 8'hD5});
        chk("R3 push pair tag", rsp_pair, 2'd3);
        issue(3'd1, 2'd0, 16'h0);
        wait_done("R2", nb);
        chk("R2 busy cycles", nb, 3);
        chk("R2 data", rsp_data, 16'hC3D5);
        chk("R3 pop pair tag", rsp_pair, 2'd0);
        chk("R6 not pc", rsp_to_pc, 1'b0);
        chk("R2 sp", sp_value, 16'h1FFE);
    endtask

    task automatic t_call_ret();
        int b, nb;
        b = wn;
        issue(3'd4, 2'd0, 16'h4567);
        wait_done("R6 call", nb);
        chk("R6 pc high", {wlog_a[b % 64], wlog_d[b % 64]}, {16'h1FFD, 8'h45});
        chk("R6 pc low", {wlog_a[(b + 1) % 64], wlog_d[(b + 1) % 64]}, {16'h1FFC, 8'h67});
        issue(3'd5, 2'd0, 16'h0);
        wait_done("R6 ret", nb);
        chk("R6 ret data", rsp_data, 16'h4567);
        chk("R6 to pc", rsp_to_pc, 1'b1);
        chk("R6 sp", sp_value, 16'h1FFE);
    endtask

    task automatic t_xtop();
        int b, nb;
        b = wn;
        issue(3'd2, 2'd0, 16'hBEEF);
        wait_done("R4", nb);
        chk("R4 busy cycles", nb, 4);
        chk("R4 old top", rsp_data, 16'h1234);
        chk("R4 pair HL", rsp_pair, 2'd2);
        chk("R4 L at SP", {wlog_a[b % 64], wlog_d[b % 64]}, {16'h1FFE, 8'hEF});
        chk("R4 H at SP+1", {wlog_a[(b + 1) % 64], wlog_d[(b + 1) % 64]}, {16'h1FFF, 8'hBE});
        chk("R4 sp kept", sp_value, 16'h1FFE);
    endtask

    task automatic t_busy_ignore();
        int nb;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_pair = 2'd0; cmd_data = 16'h5566;
        @(negedge clk);
        cmd_op = 3'd3; cmd_data = 16'h0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done("R9 busy", nb);
        chk("R9 sp ignores command while busy", sp_value, 16'h1FFC);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no extra sequence", {busy, done}, 2'b00);
        end
    endtask

    task automatic t_bad_op();
        int b, r;
        b = wn; r = rn;
        issue(3'd6, 2'd0, 16'h0BAD);
        chk("R9 code 6 no busy", busy, 1'b0);
        issue(3'd7, 2'd0, 16'h0BAD);
        repeat (3) begin
            @(negedge clk);
            chk("R9 code 7 idle", {busy, done}, 2'b00);
        end
        chk("R9 sp unchanged", sp_value, 16'h1FFC);
        chk("R9 no access", (wn - b) + (rn - r), 0);
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_spld();
        t_push();
        t_accum();
        t_call_ret();
        t_xtop();
        t_busy_ignore();
        t_bad_op();
        finish_up();
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

endmodule